// File: doc/BRIEF.md
# Mixed-Signedness Radix-4 Booth Multiplier

This block multiplies two 32-bit integers and returns the complete 64-bit product. Each operand has its own interpretation flag. When a flag is set, that operand is read as two's-complement and sign-extended from its top bit. When the flag is clear, the operand is zero-extended. One shared datapath handles all four combinations of the two flags.

The multiplier operand is recoded into radix-4 Booth digits. Before recoding it is widened by two bits, which are copies of its sign or zeros, so that an unsigned value with its top bit set still recodes correctly. Each digit scales the extended multiplicand by one of -2, -1, 0, +1 or +2. The scaled terms are shifted, summed modulo 2^64 and captured in one output register. A caller raises the request strobe for one cycle with the operands applied, and reads the product on the next cycle, when the valid flag is high.

Top module: `mulx_booth_top`

## Requirements
- R1: An active-high asynchronous reset drives `prod_valid` to 0 and `product` to 0 at once, without waiting for a clock edge.
- R2: `prod_valid` is high in the cycle after each clock edge at which `req_valid` was high. It is low in the cycle after each edge at which `req_valid` was low.
- R3: With both flags at 0, `product` equals the unsigned product of `x_in` and `y_in`, one cycle after the request.
- R4: With both flags at 1, `product` equals the two's-complement product of the sign-extended operands, truncated to 64 bits.
- R5: With `x_is_signed`=1 and `y_is_signed`=0, `product` equals the sign-extended `x_in` times the zero-extended `y_in`, modulo 2^64.
- R6: With `x_is_signed`=0 and `y_is_signed`=1, `product` equals the zero-extended `x_in` times the sign-extended `y_in`, modulo 2^64.
- R7: An unsigned `y_in` with bit 31 set gives the correct product, for example 0x7FFFFFFF × 0x80000000 = 0x3FFFFFFF80000000 and 0x80000000 × 0xFFFFFFFF (x signed) = 0x8000000080000000.
- R8: In a cycle where `req_valid` is low, changes on the operands and flags leave `product` unchanged.
- R9: Requests on consecutive cycles each give their own correct product, one cycle after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | Request strobe; operands are sampled when it is high |
| x_in | input | 32 | Multiplicand |
| y_in | input | 32 | Multiplier (Booth-recoded) |
| x_is_signed | input | 1 | 1: read `x_in` as two's-complement; 0: read it as unsigned |
| y_is_signed | input | 1 | 1: read `y_in` as two's-complement; 0: read it as unsigned |
| product | output | 64 | Registered 64-bit product |
| prod_valid | output | 1 | High for one cycle per request, one cycle after it |

## Verification
There is only one register stage. A bad recoding window, a bad extension bit or a bad partial-product shift therefore shows up as a wrong `product` in the very cycle after the request that triggers it. Errors in the extension bits appear only for particular sign and top-bit combinations. The corner operands 0x80000000 and 0xFFFFFFFF under every flag pair are the ones that expose them. A fault in the capture enable shows as a `product` that moves while the strobe is low, or as a stale value after a back-to-back request.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

   // One radix-4 Booth digit: magnitude 1 or 2 (at most one set), with sign.
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } bdigit_t;

endpackage

// File: rtl/mulx_booth_recode.sv
module mulx_booth_recode
   import mulx_pkg::*;
(
   input  logic [2:0] win,
   output bdigit_t    dig
);

   always_comb begin
      dig.one = win[1] ^ win[0];
      dig.two = (win == 3'b011) || (win == 3'b100);
      dig.neg = win[2] & ~(win[1] & win[0]);
   end

endmodule

// File: rtl/mulx_pp_gen.sv
module mulx_pp_gen
   import mulx_pkg::*;
#(
   parameter int PW    = 64,
   parameter int SHIFT = 0
)(
   input  logic [PW-1:0] xe,
   input  bdigit_t       dig,
   output logic [PW-1:0] pp
);

   if (SHIFT < 0 || SHIFT >= PW) begin : g_bad_shift
      $error("mulx_pp_gen: SHIFT out of range");
   end

   logic [PW-1:0] mag;
   logic [PW-1:0] sel;

   always_comb begin
      if (dig.two)      mag = xe << 1;
      else if (dig.one) mag = xe;
      else              mag = '0;
      sel = dig.neg ? (~mag + {{(PW-1){1'b0}}, 1'b1}) : mag;
      pp  = sel << SHIFT;
   end

   // The recoder in the neighbouring cell must hand over a legal digit.
   always_comb begin
      assert_digit_legal_R3: assert ($onehot0({dig.one, dig.two}) && (!dig.neg || dig.one || dig.two))
         else $error("illegal Booth digit");
   end

endmodule

// File: rtl/mulx_pp_sum.sv
module mulx_pp_sum #(
   parameter int PW = 64,
   parameter int N  = 17
)(
   input  logic [N-1:0][PW-1:0] pps,
   output logic [PW-1:0]        sum
);

   if (N < 1) begin : g_bad_n
      $error("mulx_pp_sum: N must be at least 1");
   end

   logic [N:0][PW-1:0] acc;

   assign acc[0] = '0;
   for (genvar i = 0; i < N; i++) begin : g_acc
      assign acc[i+1] = acc[i] + pps[i];
   end

   assign sum = acc[N];

endmodule

// File: rtl/mulx_booth_top.sv
module mulx_booth_top
   import mulx_pkg::*;
#(
   parameter int XW = 32,
   parameter int YW = 32
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   input  logic [XW-1:0]      x_in,
   input  logic [YW-1:0]      y_in,
   input  logic               x_is_signed,
   input  logic               y_is_signed,
   output logic [XW+YW-1:0]   product,
   output logic               prod_valid
);

   localparam int PW = XW + YW;      // product width
   localparam int ND = YW / 2 + 1;   // Booth digit count
   localparam int YE = 2 * ND;       // widened multiplier width

   if (XW < 2 || YW < 2) begin : g_bad_width
      $error("mulx_booth_top: operand widths must be at least 2");
   end
   if (YW % 2 != 0) begin : g_bad_parity
      $error("mulx_booth_top: YW must be even");
   end

   // Operand extension
   logic          x_top;
   logic          y_top;
   logic [PW-1:0] x_ext;
   logic [YE:0]   y_ext;   // bit 0 is the implicit zero below the LSB

   assign x_top = x_is_signed & x_in[XW-1];
   assign y_top = y_is_signed & y_in[YW-1];
   assign x_ext = {{YW{x_top}}, x_in};
   assign y_ext = {{(YE-YW){y_top}}, y_in, 1'b0};

   // Booth digits and partial products
   bdigit_t              digs [ND];
   logic [ND-1:0][PW-1:0] pps;

   for (genvar i = 0; i < ND; i++) begin : g_digit
      mulx_booth_recode u_rec (
         .win (y_ext[2*i+2 -: 3]),
         .dig (digs[i])
      );
      mulx_pp_gen #(.PW(PW), .SHIFT(2*i)) u_pp (
         .xe  (x_ext),
         .dig (digs[i]),
         .pp  (pps[i])
      );
   end

   logic [PW-1:0] sum;

   mulx_pp_sum #(.PW(PW), .N(ND)) u_sum (
      .pps (pps),
      .sum (sum)
   );

   // Output stage
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prod_valid <= 1'b0;
         product    <= '0;
      end else begin
         prod_valid <= req_valid;
         if (req_valid) product <= sum;
      end
   end

   // Behavioural product, used only by the assertions below
   logic signed [PW-1:0] ref_x;
   logic signed [PW-1:0] ref_y;
   logic signed [PW-1:0] ref_prod;

   always_comb begin
      ref_x    = x_is_signed ? $signed({{YW{x_in[XW-1]}}, x_in}) : $signed({{YW{1'b0}}, x_in});
      ref_y    = y_is_signed ? $signed({{XW{y_in[YW-1]}}, y_in}) : $signed({{XW{1'b0}}, y_in});
      ref_prod = ref_x * ref_y;
   end

   always @(posedge clk) begin
      if (rst) begin
         assert_reset_clear_R1: assert (prod_valid == 1'b0 && product == '0)
            else $error("outputs not cleared in reset");
      end
   end

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> prod_valid);

   assert_no_stale_valid_R2: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !prod_valid);

   assert_product_matches_R3: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> (product == $past(ref_prod)));

   assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> $stable(product));

endmodule

// File: tb/mulx_booth_top_tb.sv
`timescale 1ns/1ps
module mulx_booth_top_tb;

   localparam real CLK_NS = 20.0;   // 50 MHz

   typedef struct packed {
      logic [31:0] x;
      logic [31:0] y;
      logic        xs;
      logic        ys;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 64'hFFFFFFFE00000001},
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 64'h0000000000000001},
      '{32'h80000000, 32'h80000000, 1'b1, 1'b1, 64'h4000000000000000},
      '{32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b0, 64'h8000000080000000},
      '{32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b1, 64'hFFFFFFFF80000000},
      '{32'h7FFFFFFF, 32'h80000000, 1'b0, 1'b0, 64'h3FFFFFFF80000000},
      '{32'h00000003, 32'hFFFFFFFE, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFA}
   };

   localparam logic [31:0] CORNERS [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [31:0] x_in = '0;
   logic [31:0] y_in = '0;
   logic        x_is_signed = 1'b0;
   logic        y_is_signed = 1'b0;
   logic [63:0] product;
   logic        prod_valid;

   int total = 0;
   int bad   = 0;

   always #(CLK_NS/2.0) clk = ~clk;

   mulx_booth_top u_dut (
      .clk         (clk),
      .rst         (rst),
      .req_valid   (req_valid),
      .x_in        (x_in),
      .y_in        (y_in),
      .x_is_signed (x_is_signed),
      .y_is_signed (y_is_signed),
      .product     (product),
      .prod_valid  (prod_valid)
   );

   function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic as, input logic bs);
      logic signed [63:0] ea;
      logic signed [63:0] eb;
      ea = as ? $signed({{32{a[31]}}, a}) : $signed({32'h0, a});
      eb = bs ? $signed({{32{b[31]}}, b}) : $signed({32'h0, b});
      return ea * eb;
   endfunction

   function automatic string tag_of(input logic [31:0] b, input logic as, input logic bs);
      if (!bs && b[31])  return "R7";
      if (as && bs)      return "R4";
      if (as)            return "R5";
      if (bs)            return "R6";
      return "R3";
   endfunction

   task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check1(input string tag, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // Apply one request at a falling edge; result is read at the next falling edge.
   task automatic run_one(input logic [31:0] a, input logic [31:0] b, input logic as,
                          input logic bs, input logic [63:0] exp, input string tag);
      @(negedge clk);
      x_in = a; y_in = b; x_is_signed = as; y_is_signed = bs; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check1("R2", prod_valid, 1'b1);
      check64(tag, product, exp);
   endtask

   initial begin
      #(CLK_NS * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] held;
      logic [31:0] ra;
      logic [31:0] rb;

      // R1: reset state
      #(CLK_NS * 3.25);
      check1("R1", prod_valid, 1'b0);
      check64("R1", product, 64'h0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check1("R2", prod_valid, 1'b0);

      // Vector table walk (R3..R7)
      for (int i = 0; i < NV; i++) begin
         run_one(VECS[i].x, VECS[i].y, VECS[i].xs, VECS[i].ys, VECS[i].exp,
                 tag_of(VECS[i].y, VECS[i].xs, VECS[i].ys));
      end

      // Corner operands under every flag pair
      for (int f = 0; f < 4; f++) begin
         for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
               run_one(CORNERS[i], CORNERS[j], f[1], f[0],
                       model(CORNERS[i], CORNERS[j], f[1], f[0]),
                       tag_of(CORNERS[j], f[1], f[0]));
            end
         end
      end

      // Random operands
      for (int k = 0; k < 200; k++) begin
         ra = $urandom;
         rb = $urandom;
         run_one(ra, rb, k[0], k[1], model(ra, rb, k[0], k[1]), tag_of(rb, k[0], k[1]));
      end

      // R9: back-to-back requests
      @(negedge clk);
      x_in = 32'h12345678; y_in = 32'h9ABCDEF0; x_is_signed = 1'b1; y_is_signed = 1'b0;
      req_valid = 1'b1;
      for (int k = 0; k < 20; k++) begin
         ra = x_in; rb = y_in;
         held = model(ra, rb, x_is_signed, y_is_signed);
         @(negedge clk);
         check1("R9", prod_valid, 1'b1);
         check64("R9", product, held);
         x_in = $urandom; y_in = $urandom;
         x_is_signed = k[0]; y_is_signed = k[1];
      end
      req_valid = 1'b0;
      @(negedge clk);
      check1("R2", prod_valid, 1'b0);

      // R8: product holds while idle, despite input changes
      held = product;
      for (int k = 0; k < 4; k++) begin
         x_in = $urandom; y_in = $urandom; x_is_signed = ~x_is_signed;
         @(negedge clk);
         check64("R8", product, held);
         check1("R8", prod_valid, 1'b0);
      end

      // R1: asynchronous reset mid-cycle after a nonzero result
      run_one(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 64'hFFFFFFFE00000001, "R3");
      #(CLK_NS / 8.0);
      rst = 1'b1;
      #1;
      check64("R1", product, 64'h0);
      check1("R1", prod_valid, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      run_one(32'h00000007, 32'hFFFFFFF9, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFCF, "R6");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule